// File: doc/BRIEF.md
# Guarded Debug-Control Register with Access Arbitration

This block holds a 64-bit debug-control register and arbitrates every request that targets it. A request names a register through five encoding fields. It also carries the requester's privilege level (0 to 3), its security state and a set of configuration inputs. These inputs say whether level 2, level 3, the secure-level-2 feature and 32-bit support at level 1 exist. They also carry the nested-virtualization control bits, a debug-trap control and the secure-level-2 enable.

For each matching request, the block gives one registered outcome on the next cycle: a completed access, undefined, a trap to level 2 or a trap to level 3. A trap also reports exception class 0x18. A completed read returns the register contents and a completed write updates the register. Only the two low bits can be stored. Bit 0 enables invasive debug in secure user mode and bit 1 enables non-invasive debug in secure user mode. Two gated enable outputs pass these bits on to debug logic. They pass them only while the processor is secure and level 1 runs 32-bit code.

Top module: `sysreg_access_guard`

## Requirements
- R1: A request matches only when op0=2'b11, op1=3'b100, crn=4'b0001, crm=4'b0011 and op2=3'b001; a non-matching request gives rsp_valid=0 on the next cycle and leaves the register unchanged. A matching request gives rsp_valid=1 one cycle later with rsp_code 00=completed, 01=undefined, 10=trap to level 2, 11=trap to level 3.
- R2: If has_l2, has_sec_l2 or l1_a32_cap is 0, every matching request is undefined, whatever the level, security state or controls.
- R3: A matching request from level 0 is undefined.
- R4: At level 1, a non-secure request is undefined; a secure request traps to level 2 when nv_ctl[0]=1 and is otherwise undefined.
- R5: At level 2, a non-secure request is undefined; a secure request traps to level 3 when has_l3=1 and dbg_trap=1, and otherwise completes.
- R6: At level 3, a request is undefined when sec_l2_en=0 and otherwise completes.
- R7: A completed write stores req_wdata[1:0]; writes to bits 63:2 are ignored and those bits always read as zero.
- R8: A completed read returns the register contents on rsp_rdata one cycle after the request; for every other response and while idle, rsp_rdata is zero.
- R9: rsp_class is 6'h18 on both trap outcomes and 0 otherwise.
- R10: After reset both stored bits are 0 and rsp_valid is 0.
- R11: A write that ends as undefined or as a trap leaves the register unchanged.
- R12: eff_inv_en equals stored bit 0 and eff_noninv_en equals stored bit 1 while cur_secure=1 and l1_narrow=1; otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field crn |
| req_crm | input | 4 | Encoding field crm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_lvl | input | 2 | Requesting privilege level |
| cur_secure | input | 1 | Processor is in secure state |
| l1_narrow | input | 1 | Level 1 currently runs 32-bit code |
| has_l2 | input | 1 | Level 2 implemented |
| has_l3 | input | 1 | Level 3 implemented |
| has_sec_l2 | input | 1 | Secure-level-2 feature implemented |
| l1_a32_cap | input | 1 | Level 1 is able to run 32-bit code |
| nv_ctl | input | 3 | Nested-virtualization control bits |
| dbg_trap | input | 1 | Trap debug register access to level 3 |
| sec_l2_en | input | 1 | Secure level 2 enabled |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Outcome code |
| rsp_class | output | 6 | Exception class for traps |
| rsp_rdata | output | 64 | Read data |
| eff_inv_en | output | 1 | Gated invasive debug enable |
| eff_noninv_en | output | 1 | Gated non-invasive debug enable |

## Verification
A completed write updates the register on the same edge that registers its response. The next request can read at once. Requests are therefore issued back to back with no idle cycle, so a read lands one cycle after the write it depends on, and the scoreboard expects the newly written value. In a second case a trapped or undefined write is followed directly by a read. The read must return the older contents, which shows that the outcome and the register update were decided together in one cycle.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        OUT_DONE  = 2'b00,
        OUT_UNDEF = 2'b01,
        OUT_TRAP2 = 2'b10,
        OUT_TRAP3 = 2'b11
    } outcome_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } enc_t;

    typedef struct packed {
        logic has_l2;
        logic has_sec_l2;
        logic l1_a32_cap;
        logic has_l3;
        logic nv_lo;
        logic dbg_trap;
        logic sec_l2_en;
    } cfg_t;

    localparam enc_t CTL_KEY = '{op0: 2'b11, op1: 3'b100, crn: 4'b0001,
                                 crm: 4'b0011, op2: 3'b001};

endpackage

// File: rtl/sag_match.sv
module sag_match
    import sag_pkg::*;
#(
    parameter enc_t KEY = CTL_KEY
) (
    input  enc_t enc,
    output logic hit
);
    localparam int ENC_W = $bits(enc_t);

    logic [ENC_W-1:0] bit_eq;

    for (genvar i = 0; i < ENC_W; i++) begin : g_cmp
        assign bit_eq[i] = (enc[i] == KEY[i]);
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/sag_policy.sv
module sag_policy
    import sag_pkg::*;
(
    input  logic [1:0] lvl,
    input  logic       secure,
    input  cfg_t       cfg,
    output outcome_e   outcome
);
    logic present;

    assign present = cfg.has_l2 & cfg.has_sec_l2 & cfg.l1_a32_cap;

    always_comb begin
        outcome = OUT_UNDEF;
        if (present) begin
            case (lvl)
                2'd0: outcome = OUT_UNDEF;
                2'd1: begin
                    if (secure && cfg.nv_lo) outcome = OUT_TRAP2;
                    else                     outcome = OUT_UNDEF;
                end
                2'd2: begin
                    if (!secure)                         outcome = OUT_UNDEF;
                    else if (cfg.has_l3 && cfg.dbg_trap) outcome = OUT_TRAP3;
                    else                                 outcome = OUT_DONE;
                end
                default: begin
                    if (cfg.sec_l2_en) outcome = OUT_DONE;
                    else               outcome = OUT_UNDEF;
                end
            endcase
        end
    end
endmodule

// File: rtl/sag_store.sv
module sag_store #(
    parameter int DATA_W = 64,
    parameter int KEEP_W = 2
) (
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] kept
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < KEEP_W) begin : g_keep
            assign kept[i] = wdata[i];
        end else begin : g_zero
            assign kept[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sysreg_access_guard.sv
module sysreg_access_guard
    import sag_pkg::*;
#(
    parameter int             DATA_W     = 64,
    parameter int             KEEP_W     = 2,
    parameter int             CLASS_W    = 6,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cur_lvl,
    input  logic              cur_secure,
    input  logic              l1_narrow,
    input  logic              has_l2,
    input  logic              has_l3,
    input  logic              has_sec_l2,
    input  logic              l1_a32_cap,
    input  logic [2:0]        nv_ctl,
    input  logic              dbg_trap,
    input  logic              sec_l2_en,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [CLASS_W-1:0] rsp_class,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              eff_inv_en,
    output logic              eff_noninv_en
);
    typedef struct packed {
        logic               rsp_valid;
        outcome_e           code;
        logic [CLASS_W-1:0] cls;
        logic [DATA_W-1:0]  rdata;
        logic [DATA_W-1:0]  ctl;
    } state_t;

    state_t state_d, state_q;

    enc_t              enc;
    cfg_t              cfg;
    logic              hit;
    outcome_e          outcome;
    logic [DATA_W-1:0] kept_wdata;
    logic [DATA_W-1:0] ctl_bits_q;
    logic              gate_open;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn,
                   crm: req_crm, op2: req_op2};
    assign cfg = '{has_l2: has_l2, has_sec_l2: has_sec_l2,
                   l1_a32_cap: l1_a32_cap, has_l3: has_l3,
                   nv_lo: nv_ctl[0], dbg_trap: dbg_trap,
                   sec_l2_en: sec_l2_en};

    sag_match #(.KEY(CTL_KEY)) u_match (
        .enc (enc),
        .hit (hit)
    );

    sag_policy u_policy (
        .lvl     (cur_lvl),
        .secure  (cur_secure),
        .cfg     (cfg),
        .outcome (outcome)
    );

    sag_store #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_store (
        .wdata (req_wdata),
        .kept  (kept_wdata)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        state_d.code      = OUT_DONE;
        state_d.cls       = '0;
        state_d.rdata     = '0;
        if (req_valid && hit) begin
            state_d.rsp_valid = 1'b1;
            state_d.code      = outcome;
            if (outcome == OUT_TRAP2 || outcome == OUT_TRAP3) begin
                state_d.cls = TRAP_CLASS;
            end
            if (outcome == OUT_DONE) begin
                if (req_write) state_d.ctl   = kept_wdata;
                else           state_d.rdata = state_q.ctl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl_bits_q = state_q.ctl;
    assign gate_open  = cur_secure & l1_narrow;

    assign rsp_valid     = state_q.rsp_valid;
    assign rsp_code      = state_q.code;
    assign rsp_class     = state_q.cls;
    assign rsp_rdata     = state_q.rdata;
    assign eff_inv_en    = gate_open & state_q.ctl[0];
    assign eff_noninv_en = gate_open & state_q.ctl[1];
endmodule

module sag_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op0,
    input logic [2:0]        req_op1,
    input logic [3:0]        req_crn,
    input logic [3:0]        req_crm,
    input logic [2:0]        req_op2,
    input logic [1:0]        cur_lvl,
    input logic              has_l2,
    input logic              has_sec_l2,
    input logic              l1_a32_cap,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [5:0]        rsp_class,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [DATA_W-1:0] ctl_bits_q
);
    logic sel;
    assign sel = req_valid && req_op0 == 2'b11 && req_op1 == 3'b100 &&
                 req_crn == 4'b0001 && req_crm == 4'b0011 && req_op2 == 3'b001;

    // R1
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel) |=> (!rsp_valid && $stable(ctl_bits_q)));

    // R2
    absent_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !(has_l2 && has_sec_l2 && l1_a32_cap)) |=> (rsp_code == 2'b01));

    // R3
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cur_lvl == 2'd0) |=> (rsp_valid && rsp_code == 2'b01));

    // R9
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code[1]) |-> (rsp_class == 6'h18));

    // R9
    class_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_code[1]) |-> (rsp_class == 6'h00));

    // R7
    resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bits_q[DATA_W-1:2] == '0 && rsp_rdata[DATA_W-1:2] == '0);

    // R11
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |-> $stable(ctl_bits_q));

    // R8
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0));
endmodule

bind sysreg_access_guard sag_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sysreg_access_guard_test.sv
`timescale 1ns/1ps
module sysreg_access_guard_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_op0;
    logic [2:0]  req_op1;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [63:0] req_wdata;
    logic [1:0]  cur_lvl;
    logic        cur_secure, l1_narrow, has_l2, has_l3, has_sec_l2, l1_a32_cap;
    logic [2:0]  nv_ctl;
    logic        dbg_trap, sec_l2_en;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [5:0]  rsp_class;
    logic [63:0] rsp_rdata;
    logic        eff_inv_en, eff_noninv_en;

    typedef struct packed {
        logic [1:0]  code;
        logic [5:0]  cls;
        logic [63:0] rdata;
        logic        vld;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic [1:0] model_ctl = 2'b00;
    logic done = 1'b0;

    always #4 clk = ~clk;

    sysreg_access_guard uut (.*);

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] expect_code(input logic [1:0] lv, input logic sec);
        if (!(has_l2 && has_sec_l2 && l1_a32_cap)) return 2'b01;   // R2
        if (lv == 2'd0) return 2'b01;                               // R3
        if (lv == 2'd1) return (sec && nv_ctl[0]) ? 2'b10 : 2'b01;  // R4
        if (lv == 2'd2) begin                                       // R5
            if (!sec) return 2'b01;
            return (has_l3 && dbg_trap) ? 2'b11 : 2'b00;
        end
        return sec_l2_en ? 2'b00 : 2'b01;                           // R6
    endfunction

    // drive one request at the falling edge and record what it must produce
    task automatic issue(input logic wr, input logic [1:0] lv, input logic sec,
                         input logic [63:0] wd, input logic match);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; cur_lvl = lv; cur_secure = sec;
        req_wdata = wd;
        req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b0001;
        req_crm = match ? 4'b0011 : 4'b0010; req_op2 = 3'b001;
        e = '0;
        e.vld = match;
        if (match) begin
            e.code = expect_code(lv, sec);
            e.cls  = e.code[1] ? 6'h18 : 6'h00;
            if (e.code == 2'b00) begin
                if (wr) model_ctl = wd[1:0];
                else    e.rdata   = {62'd0, model_ctl};
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compares each response just after the edge that makes it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_valid == e.vld, "R1 rsp_valid", {63'd0, rsp_valid}, {63'd0, e.vld});
                if (e.vld) begin
                    check(rsp_code == e.code, "R2-6 code", {62'd0, rsp_code}, {62'd0, e.code});
                    check(rsp_class == e.cls, "R9 class", {58'd0, rsp_class}, {58'd0, e.cls});
                    check(rsp_rdata == e.rdata, "R8 rdata", rsp_rdata, e.rdata);
                end
            end else if (rst_n && rsp_valid) begin
                check(1'b0, "R1 spurious response", 64'd1, 64'd0);
            end
        end
    end

    initial begin
        #1000000;
        check(1'b0, "watchdog", 64'd0, 64'd1);
        done = 1'b1;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_op0 = '0; req_op1 = '0; req_crn = '0; req_crm = '0; req_op2 = '0;
        req_wdata = '0; cur_lvl = 2'd3; cur_secure = 1'b1; l1_narrow = 1'b1;
        has_l2 = 1'b1; has_l3 = 1'b1; has_sec_l2 = 1'b1; l1_a32_cap = 1'b1;
        nv_ctl = 3'b000; dbg_trap = 1'b0; sec_l2_en = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(rsp_valid == 1'b0, "R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check({eff_noninv_en, eff_inv_en} == 2'b00, "R10 bits",
              {62'd0, eff_noninv_en, eff_inv_en}, 64'd0);
        rst_n = 1'b1;
        issue(1'b0, 2'd3, 1'b1, 64'd0, 1'b1);                    // R10 read zero
        // R5 R7 R8 secure level 2 write of all ones, read back at once
        issue(1'b1, 2'd2, 1'b1, {64{1'b1}}, 1'b1);
        issue(1'b0, 2'd2, 1'b1, 64'd0, 1'b1);
        // R6 R7 level 3 write with reserved bits set
        issue(1'b1, 2'd3, 1'b0, 64'hFFFF_0000_0000_FFFD, 1'b1);
        issue(1'b0, 2'd3, 1'b0, 64'd0, 1'b1);
        // R1 encoding miss, then read shows no change
        issue(1'b1, 2'd3, 1'b1, 64'd2, 1'b0);
        issue(1'b0, 2'd3, 1'b1, 64'd0, 1'b1);
        // R3 level 0 write refused (R11)
        issue(1'b1, 2'd0, 1'b1, 64'd2, 1'b1);
        issue(1'b0, 2'd3, 1'b1, 64'd0, 1'b1);
        // R4 level 1
        issue(1'b1, 2'd1, 1'b0, 64'd2, 1'b1);
        idle(); nv_ctl = 3'b001;
        issue(1'b1, 2'd1, 1'b1, 64'd2, 1'b1);                    // trap to 2, R11
        issue(1'b1, 2'd1, 1'b0, 64'd2, 1'b1);                    // non-secure still undef
        idle(); nv_ctl = 3'b110;
        issue(1'b0, 2'd1, 1'b1, 64'd0, 1'b1);                    // undef
        issue(1'b0, 2'd3, 1'b1, 64'd0, 1'b1);
        // R5 level 2 paths
        issue(1'b1, 2'd2, 1'b0, 64'd2, 1'b1);
        idle(); dbg_trap = 1'b1;
        issue(1'b1, 2'd2, 1'b1, 64'd2, 1'b1);                    // trap to 3
        issue(1'b0, 2'd2, 1'b0, 64'd0, 1'b1);
        idle(); has_l3 = 1'b0;
        issue(1'b1, 2'd2, 1'b1, 64'd2, 1'b1);                    // completes
        issue(1'b0, 2'd2, 1'b1, 64'd0, 1'b1);
        // R6 level 3 disabled
        idle(); sec_l2_en = 1'b0;
        issue(1'b1, 2'd3, 1'b1, 64'd3, 1'b1);
        idle(); sec_l2_en = 1'b1; has_l3 = 1'b1; dbg_trap = 1'b0;
        issue(1'b0, 2'd3, 1'b1, 64'd0, 1'b1);
        // R2 missing features override everything
        idle(); has_l2 = 1'b0;
        issue(1'b1, 2'd3, 1'b1, 64'd1, 1'b1);
        idle(); has_l2 = 1'b1; has_sec_l2 = 1'b0;
        issue(1'b0, 2'd2, 1'b1, 64'd0, 1'b1);
        idle(); has_sec_l2 = 1'b1; l1_a32_cap = 1'b0; nv_ctl = 3'b001;
        issue(1'b1, 2'd1, 1'b1, 64'd1, 1'b1);
        idle(); l1_a32_cap = 1'b1;
        // R12 gated enables
        issue(1'b1, 2'd3, 1'b1, 64'd3, 1'b1);
        idle();
        @(negedge clk);
        check({eff_noninv_en, eff_inv_en} == 2'b11, "R12 open",
              {62'd0, eff_noninv_en, eff_inv_en}, 64'd3);
        cur_secure = 1'b0; #1;
        check({eff_noninv_en, eff_inv_en} == 2'b00, "R12 non-secure",
              {62'd0, eff_noninv_en, eff_inv_en}, 64'd0);
        cur_secure = 1'b1; l1_narrow = 1'b0; #1;
        check({eff_noninv_en, eff_inv_en} == 2'b00, "R12 wide level 1",
              {62'd0, eff_noninv_en, eff_inv_en}, 64'd0);
        l1_narrow = 1'b1;
        issue(1'b1, 2'd3, 1'b1, 64'd1, 1'b1);
        idle();
        @(negedge clk);
        check({eff_noninv_en, eff_inv_en} == 2'b01, "R12 single bit",
              {62'd0, eff_noninv_en, eff_inv_en}, 64'd1);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule